// File: doc/BRIEF.md
# Palette and Direct-Colour Pixel Unpacker

This block takes 32-bit frame-buffer words and turns each one into a run of pixels with 6-bit red, green and blue channels. A 3-bit mode input picks the pixel depth. At 1, 2, 4 and 8 bits per pixel, the pixel value is an index into a 256-entry, 16-bit colour table. At 16 bits per pixel (two layouts), 12 bits per pixel and 24 bits per pixel, the pixel carries its colour directly. For example, a 320x240 frame needs 76800 bytes at 8 bits per pixel and 153600 bytes at 16 bits per pixel.

The colour table is written and read through a plain address/data port. Three control inputs shape the output. One reverses the byte order within each word. One reverses the order of the pixels within each byte, for depths below 8 bits. One exchanges the red and blue channels. Words enter through a valid/ready handshake, and pixels leave through a second valid/ready handshake. The mode and the three control inputs must be held steady while a word is being unpacked.

Top module: `pix_unpack_top`

## Requirements
- R1: While reset is asserted and right after it is released, `pix_valid_o` is 0 and `word_ready_o` is 1.
- R2: The number of pixels produced from one word depends on the mode. Mode 000 gives 32, 001 gives 16, 010 gives 8, 011 gives 4, 100 gives 2, 101 gives 1, 110 gives 2 and 111 gives 2. Pixels leave in order of ascending pixel number. A new word is taken only in the same cycle that the last pixel of the current word is taken, or when no word is held.
- R3: Modes 000, 001, 010 and 011 (1, 2, 4 and 8 bits per pixel) use the pixel value as a zero-extended index into the colour table, and the output is the colour of the selected entry.
- R4: A colour-table entry is decoded as follows. Red is bits 4:0. Blue is bits 14:10. Green is bits 9:5 followed by bit 15 as the least significant bit. Each 5-bit channel is widened to 6 bits as {x, x[4]}.
- R5: Mode 100 (16 bits per pixel) decodes each 16-bit pixel exactly as a colour-table entry is decoded under R4.
- R6: Mode 110 (16 bits per pixel, 5:6:5) takes red from bits 4:0 and widens it as {x, x[4]}. It takes green from bits 10:5 unchanged. It takes blue from bits 15:11 and widens it as {x, x[4]}.
- R7: Mode 111 (12 bits per pixel) uses bits 11:0 of each 16-bit half. Red is bits 3:0, green is bits 7:4 and blue is bits 11:8. Each 4-bit channel is widened as {x, x[3:2]}.
- R8: Mode 101 (24 bits per pixel) uses bits 23:0 of the word as one pixel. The channels are red [7:2], green [15:10] and blue [23:18]. The word is released after that single pixel.
- R9: With little-endian byte order, pixel p lies at bits [p*bpp +: bpp] of the word. With the byte-order input high, the word's four bytes are reversed first, and the same rule then applies.
- R10: With the pixel-order input high, in the 1, 2 and 4 bits-per-pixel modes, the pixel numbering within each byte is reversed, so the first pixel of a byte sits at its most significant end. The pixel-order input has no effect in the other modes.
- R11: With the swap input high, the red and blue outputs are exchanged. Green is unchanged.
- R12: A colour-table write takes effect at the clock edge. `pal_rdata_o` returns the stored 16-bit entry at `pal_addr_i` unchanged and without delay.
- R13: While `pix_valid_o` is 1 and `pix_ready_i` is 0, the output pixel and `pix_valid_o` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Pixel depth and format select |
| byte_swap_i | input | 1 | Reverse the byte order within a word |
| pix_rev_i | input | 1 | Reverse the pixel order within a byte (below 8 bpp) |
| rb_swap_i | input | 1 | Exchange the red and blue outputs |
| pal_we_i | input | 1 | Colour-table write enable |
| pal_addr_i | input | 8 | Colour-table address for write and read |
| pal_wdata_i | input | 16 | Colour-table write data |
| pal_rdata_o | output | 16 | Colour-table read data |
| word_valid_i | input | 1 | Input word valid |
| word_data_i | input | 32 | Input frame-buffer word |
| word_ready_o | output | 1 | Input word accepted when high together with valid |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_ready_i | input | 1 | Downstream ready for a pixel |
| pix_r_o | output | 6 | Red channel |
| pix_g_o | output | 6 | Green channel |
| pix_b_o | output | 6 | Blue channel |

## Verification
The hardest case to reach is a word handed over in the same cycle that the last pixel of the previous word drains while the consumer stalls at random. An off-by-one in the pixel count, or a lost word, shows up only on that edge. The stimulus therefore keeps a new word waiting almost all the time and toggles `pix_ready_i` at random. It runs every mode under several combinations of byte order, pixel order and swap, and checks every output pixel in order against an independent model.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;
  localparam int WORD_W = 32;
  localparam int CH_W   = 6;
  localparam int IDX_W  = $clog2(WORD_W);

  typedef enum logic [2:0] {
    MODE_B1    = 3'b000,
    MODE_B2    = 3'b001,
    MODE_B4    = 3'b010,
    MODE_B8    = 3'b011,
    MODE_D1555 = 3'b100,
    MODE_D24   = 3'b101,
    MODE_D565  = 3'b110,
    MODE_D444  = 3'b111
  } pix_mode_e;

  // last pixel number within a word
  function automatic logic [IDX_W-1:0] last_idx(input pix_mode_e m);
    case (m)
      MODE_B1:  last_idx = IDX_W'(31);
      MODE_B2:  last_idx = IDX_W'(15);
      MODE_B4:  last_idx = IDX_W'(7);
      MODE_B8:  last_idx = IDX_W'(3);
      MODE_D24: last_idx = IDX_W'(0);
      default:  last_idx = IDX_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/pix_pal_ram.sv
module pix_pal_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [AW-1:0] lk_addr_i,
  output logic [DW-1:0] lk_data_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o   = mem[addr_i];
  assign lk_data_o = mem[lk_addr_i];

  AST_PAL_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && addr_i == $past(addr_i)) |-> rdata_o == $past(wdata_i)); // R12
endmodule

// File: rtl/pix_extract.sv
module pix_extract
  import pix_unpack_pkg::*;
(
  input  pix_mode_e          mode_i,
  input  logic               byte_swap_i,
  input  logic               pix_rev_i,
  input  logic [WORD_W-1:0]  word_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [23:0]        val_o
);
  localparam int NBYTE = WORD_W / 8;

  logic [WORD_W-1:0] w;
  logic [IDX_W-1:0]  p;
  logic [IDX_W-1:0]  shamt;
  logic [WORD_W-1:0] shifted;

  for (genvar g = 0; g < NBYTE; g++) begin : g_bytes
    assign w[g*8 +: 8] = byte_swap_i ? word_i[(NBYTE-1-g)*8 +: 8] : word_i[g*8 +: 8];
  end

  always_comb begin
    p = idx_i;
    if (pix_rev_i) begin
      case (mode_i)
        MODE_B1: p = idx_i ^ IDX_W'(7);
        MODE_B2: p = idx_i ^ IDX_W'(3);
        MODE_B4: p = idx_i ^ IDX_W'(1);
        default: p = idx_i;
      endcase
    end
    case (mode_i)
      MODE_B1:  shamt = p;
      MODE_B2:  shamt = {p[IDX_W-2:0], 1'b0};
      MODE_B4:  shamt = {p[IDX_W-3:0], 2'b0};
      MODE_B8:  shamt = {p[IDX_W-4:0], 3'b0};
      MODE_D24: shamt = '0;
      default:  shamt = {p[0], 4'b0};
    endcase
    shifted = w >> shamt;
    case (mode_i)
      MODE_B1:  val_o = {23'b0, shifted[0]};
      MODE_B2:  val_o = {22'b0, shifted[1:0]};
      MODE_B4:  val_o = {20'b0, shifted[3:0]};
      MODE_B8:  val_o = {16'b0, shifted[7:0]};
      MODE_D24: val_o = shifted[23:0];
      default:  val_o = {8'b0, shifted[15:0]};
    endcase
  end
endmodule

// File: rtl/pix_color.sv
module pix_color
  import pix_unpack_pkg::*;
(
  input  pix_mode_e        mode_i,
  input  logic             rb_swap_i,
  input  logic [23:0]      val_i,
  input  logic [15:0]      pal_i,
  output logic [CH_W-1:0]  r_o,
  output logic [CH_W-1:0]  g_o,
  output logic [CH_W-1:0]  b_o
);
  logic [15:0]     e;
  logic [CH_W-1:0] r, g, b;

  always_comb begin
    e = (mode_i == MODE_D1555) ? val_i[15:0] : pal_i;
    case (mode_i)
      MODE_D565: begin
        r = {val_i[4:0], val_i[4]};
        g = val_i[10:5];
        b = {val_i[15:11], val_i[15]};
      end
      MODE_D444: begin
        r = {val_i[3:0], val_i[3:2]};
        g = {val_i[7:4], val_i[7:6]};
        b = {val_i[11:8], val_i[11:10]};
      end
      MODE_D24: begin
        r = val_i[7:2];
        g = val_i[15:10];
        b = val_i[23:18];
      end
      default: begin // table entries and 1:5:5:5 share one layout
        r = {e[4:0], e[4]};
        g = {e[9:5], e[15]};
        b = {e[14:10], e[14]};
      end
    endcase
    r_o = rb_swap_i ? b : r;
    b_o = rb_swap_i ? r : b;
    g_o = g;
  end
endmodule

// File: rtl/pix_unpack_top.sv
module pix_unpack_top
  import pix_unpack_pkg::*;
#(
  parameter int PAL_DEPTH = 256,
  parameter int PAL_W     = 16,
  localparam int PAL_AW   = $clog2(PAL_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              byte_swap_i,
  input  logic              pix_rev_i,
  input  logic              rb_swap_i,
  input  logic              pal_we_i,
  input  logic [PAL_AW-1:0] pal_addr_i,
  input  logic [PAL_W-1:0]  pal_wdata_i,
  output logic [PAL_W-1:0]  pal_rdata_o,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_data_i,
  output logic              word_ready_o,
  output logic              pix_valid_o,
  input  logic              pix_ready_i,
  output logic [CH_W-1:0]   pix_r_o,
  output logic [CH_W-1:0]   pix_g_o,
  output logic [CH_W-1:0]   pix_b_o
);
  pix_mode_e         mode;
  logic              full_q;
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;
  logic              last, take_pix, take_word;
  logic [23:0]       val;
  logic [PAL_W-1:0]  pal_ent;

  assign mode         = pix_mode_e'(mode_i);
  assign last         = idx_q == last_idx(mode);
  assign take_pix     = full_q && pix_ready_i;
  assign word_ready_o = !full_q || (pix_ready_i && last);
  assign take_word    = word_valid_i && word_ready_o;
  assign pix_valid_o  = full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      word_q <= '0;
      idx_q  <= '0;
    end else if (take_word) begin
      full_q <= 1'b1;
      word_q <= word_data_i;
      idx_q  <= '0;
    end else if (take_pix) begin
      idx_q <= idx_q + 1'b1;
      if (last) full_q <= 1'b0;
    end
  end

  pix_extract u_extract (
    .mode_i      (mode),
    .byte_swap_i (byte_swap_i),
    .pix_rev_i   (pix_rev_i),
    .word_i      (word_q),
    .idx_i       (idx_q),
    .val_o       (val)
  );

  pix_pal_ram #(.DEPTH(PAL_DEPTH), .DW(PAL_W)) u_pal (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (pal_we_i),
    .addr_i    (pal_addr_i),
    .wdata_i   (pal_wdata_i),
    .rdata_o   (pal_rdata_o),
    .lk_addr_i (val[PAL_AW-1:0]),
    .lk_data_o (pal_ent)
  );

  pix_color u_color (
    .mode_i    (mode),
    .rb_swap_i (rb_swap_i),
    .val_i     (val),
    .pal_i     (pal_ent),
    .r_o       (pix_r_o),
    .g_o       (pix_g_o),
    .b_o       (pix_b_o)
  );

  AST_HOLD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && !pix_ready_i) |=> pix_valid_o); // R13
  AST_HOLD_PIXEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && !pix_ready_i && !pal_we_i && $stable(mode_i) && $stable(rb_swap_i)
     && $stable(byte_swap_i) && $stable(pix_rev_i))
    |=> ($stable(pix_r_o) && $stable(pix_g_o) && $stable(pix_b_o))); // R13
  AST_NO_TAKE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && !pix_ready_i) |-> !word_ready_o); // R2
  AST_ACCEPT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && word_ready_o) |=> pix_valid_o); // R2
  AST_D24_ONE_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && pix_ready_i && mode_i == 3'b101) |-> word_ready_o); // R8
endmodule

// File: tb/pix_unpack_top_bench.sv
`timescale 1ns/1ps
module pix_unpack_top_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  mode_i = '0;
  logic        byte_swap_i = 0, pix_rev_i = 0, rb_swap_i = 0;
  logic        pal_we_i = 0;
  logic [7:0]  pal_addr_i = '0;
  logic [15:0] pal_wdata_i = '0;
  logic [15:0] pal_rdata_o;
  logic        word_valid_i = 0;
  logic [31:0] word_data_i = '0;
  logic        word_ready_o, pix_valid_o;
  logic        pix_ready_i = 0;
  logic [5:0]  pix_r_o, pix_g_o, pix_b_o;

  int checks = 0, errors = 0;
  logic [15:0] pal_ref [256];
  logic [17:0] exp_q [$];

  always #2.5 clk = ~clk;

  pix_unpack_top u_pix_unpack_top (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .byte_swap_i(byte_swap_i),
    .pix_rev_i(pix_rev_i), .rb_swap_i(rb_swap_i), .pal_we_i(pal_we_i),
    .pal_addr_i(pal_addr_i), .pal_wdata_i(pal_wdata_i), .pal_rdata_o(pal_rdata_o),
    .word_valid_i(word_valid_i), .word_data_i(word_data_i), .word_ready_o(word_ready_o),
    .pix_valid_o(pix_valid_o), .pix_ready_i(pix_ready_i),
    .pix_r_o(pix_r_o), .pix_g_o(pix_g_o), .pix_b_o(pix_b_o));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int depth(input int m);
    case (m)
      0: return 1; 1: return 2; 2: return 4; 3: return 8;
      5: return 24; 7: return 12; default: return 16;
    endcase
  endfunction

  function automatic int npix(input int m);
    return (m == 5) ? 1 : (m >= 4) ? 2 : 32 / depth(m);
  endfunction

  function automatic int get_byte(input logic [31:0] w, input int logical, input bit bs);
    int phys;
    phys = bs ? 3 - logical : logical;
    return int'((w >> (phys * 8)) & 32'hFF);
  endfunction

  // R9 R10: locate pixel p in the stored word
  function automatic int raw_pixel(input logic [31:0] w, input int m, input int p, input bit bs, input bit pr);
    int d, ppb, bi, k;
    d = depth(m);
    if (d <= 8) begin
      ppb = 8 / d; bi = p / ppb; k = p % ppb;
      if (pr) k = ppb - 1 - k;
      return (get_byte(w, bi, bs) >> (k * d)) & ((1 << d) - 1);
    end
    if (m == 5)
      return get_byte(w, 0, bs) | (get_byte(w, 1, bs) << 8) | (get_byte(w, 2, bs) << 16);
    return get_byte(w, 2 * p, bs) | (get_byte(w, 2 * p + 1, bs) << 8);
  endfunction

  function automatic int wide5(input int x); return ((x << 1) | (x >> 4)) & 63; endfunction
  function automatic int wide4(input int x); return ((x << 2) | (x >> 2)) & 63; endfunction

  // R3..R8, R11
  function automatic logic [17:0] ref_rgb(input int v, input int m, input bit sw);
    int r, g, b, e;
    if (m <= 4) begin
      e = (m == 4) ? v : int'(pal_ref[v]);
      r = wide5(e & 31);
      g = (((e >> 5) & 31) << 1) | ((e >> 15) & 1);
      b = wide5((e >> 10) & 31);
    end else if (m == 6) begin
      r = wide5(v & 31); g = (v >> 5) & 63; b = wide5((v >> 11) & 31);
    end else if (m == 7) begin
      r = wide4(v & 15); g = wide4((v >> 4) & 15); b = wide4((v >> 8) & 15);
    end else begin
      r = (v >> 2) & 63; g = (v >> 10) & 63; b = (v >> 18) & 63;
    end
    if (sw) begin int t; t = r; r = b; b = t; end
    return {6'(r), 6'(g), 6'(b)};
  endfunction

  task automatic run_stream(input int m, input bit bs, input bit pr, input bit sw, input int nwords);
    int left;
    left = nwords;
    mode_i = 3'(m); byte_swap_i = bs; pix_rev_i = pr; rb_swap_i = sw;
    while (left > 0 || word_valid_i || exp_q.size() > 0 || pix_valid_o) begin
      @(negedge clk);
      if (pix_valid_o) begin
        if (exp_q.size() == 0)
          check(0, "R2 extra pixel", 1, 0);
        else
          check({pix_r_o, pix_g_o, pix_b_o} == exp_q[0],
                $sformatf("R3-path mode%0d pixel R4 R5 R6 R7 R8 R9 R10 R11", m),
                {14'b0, pix_r_o, pix_g_o, pix_b_o}, {14'b0, exp_q[0]});
      end else begin
        check(1, "R2 idle", 0, 0);
      end
      if (!word_valid_i && left > 0 && ($urandom % 8) != 0) begin
        word_valid_i = 1;
        word_data_i = $urandom;
      end
      pix_ready_i = ($urandom % 4) != 0;
      #1;
      if (pix_valid_o && pix_ready_i && exp_q.size() > 0) void'(exp_q.pop_front());
      if (word_valid_i && word_ready_o) begin
        for (int p = 0; p < npix(m); p++)
          exp_q.push_back(ref_rgb(raw_pixel(word_data_i, m, p, bs, pr), m, sw));
        left--;
        @(posedge clk);
        #0.5 word_valid_i = 0;
        if (pix_valid_o) begin end
        // pixel state advanced at the edge; resume at next negedge
      end
    end
    pix_ready_i = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pix_valid_o == 0, "R1 valid in reset", pix_valid_o, 0);
    check(word_ready_o == 1, "R1 ready in reset", word_ready_o, 1);
    rst_ni = 1;
    @(negedge clk);
    check(pix_valid_o == 0, "R1 valid after reset", pix_valid_o, 0);
    check(word_ready_o == 1, "R1 ready after reset", word_ready_o, 1);

    // R12: fill and read back the colour table
    for (int i = 0; i < 256; i++) begin
      pal_ref[i] = 16'((i * 40503 + 7919) ^ (i << 9));
      pal_we_i = 1; pal_addr_i = 8'(i); pal_wdata_i = pal_ref[i];
      @(negedge clk);
      check(pal_rdata_o == pal_ref[i], "R12 readback", pal_rdata_o, pal_ref[i]);
    end
    pal_we_i = 0;
    for (int i = 0; i < 256; i += 37) begin
      pal_addr_i = 8'(i); #1;
      check(pal_rdata_o == pal_ref[i], "R12 read", pal_rdata_o, pal_ref[i]);
    end

    // R13: stalled output is held
    mode_i = 3'b110; word_data_i = 32'h1234_ABCD; word_valid_i = 1; pix_ready_i = 0;
    @(negedge clk);
    word_valid_i = 0;
    begin
      logic [17:0] first;
      first = {pix_r_o, pix_g_o, pix_b_o};
      check(first == ref_rgb(32'hABCD, 6, 0), "R6 R13 first pixel", first, ref_rgb(32'hABCD, 6, 0));
      repeat (4) @(negedge clk);
      check(pix_valid_o && {pix_r_o, pix_g_o, pix_b_o} == first, "R13 hold", {pix_r_o, pix_g_o, pix_b_o}, first);
      check(word_ready_o == 0, "R2 busy not ready", word_ready_o, 0);
    end
    pix_ready_i = 1;
    @(negedge clk);
    check({pix_r_o, pix_g_o, pix_b_o} == ref_rgb(32'h1234, 6, 0), "R6 second pixel",
          {pix_r_o, pix_g_o, pix_b_o}, ref_rgb(32'h1234, 6, 0));
    @(negedge clk);
    pix_ready_i = 0;
    check(pix_valid_o == 0, "R2 word drained", pix_valid_o, 0);

    for (int m = 0; m < 8; m++)
      for (int c = 0; c < 8; c += 3)
        run_stream(m, c[0], c[1], c[2] ^ m[0], 6);
    run_stream(0, 1, 1, 1, 4);
    run_stream(2, 0, 1, 0, 4);
    run_stream(3, 1, 1, 0, 4);
    run_stream(5, 1, 0, 1, 8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule